// File: doc/BRIEF.md
# Bus-Start Watchdog Supervisor

This block supervises a host processor by listening to its two-wire serial bus. Every START condition on that bus (SDA falling while SCL is high) counts as proof of life and restarts a watchdog countdown. If the countdown runs out before the next START arrives, the block drives an active-low reset for a fixed hold time. It then rearms the watchdog with the full selected period.

The same reset output also acts as a power-on reset. When the supply-good input goes high, the output stays low for the hold time before it is released. Whenever supply-good is low, the output is forced low at once, without waiting for a clock edge.

All timing is measured in pulses of a one-cycle tick enable, nominally one per millisecond. A two-bit select input picks one of three watchdog periods, or turns the watchdog off.

Top module: `bus_wdog_supervisor`

## Requirements
- R1: `rst_n_o` is low whenever `supply_ok` is low, combinationally and independent of the clock.
- R2: After `supply_ok` rises, `rst_n_o` stays low for `RST_TICKS` ticks and is then released.
- R3: A START is SDA falling while SCL is high, judged on two-flop synchronized copies of both lines. Each START restarts the watchdog count from the full selected period.
- R4: If no START is seen for a whole watchdog period, `rst_n_o` goes low.
- R5: The period is selected by `wd_sel`: 2'b10 gives `SHORT_TICKS` (250), 2'b01 gives `MID_TICKS` (750), 2'b00 gives `LONG_TICKS` (1750), and 2'b11 turns the watchdog off.
- R6: A watchdog-caused reset lasts `RST_TICKS` ticks (250), the same as the power-on hold.
- R7: A START that arrives while `rst_n_o` is low neither lengthens nor shortens the reset.
- R8: When a reset is released, the watchdog reloads the full period of the current selection.
- R9: A change of `wd_sel` while watching reloads the count with the new period on the next tick.
- R10: With `wd_sel` = 2'b11 the count is frozen and no watchdog reset is ever produced. Selecting a period again reloads it on the next tick.
- R11: SDA falling while SCL is low is not a START and does not refresh the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| tick_ms | input | 1 | One-cycle time-base enable, nominally 1 ms |
| scl | input | 1 | Serial bus clock line (asynchronous) |
| sda | input | 1 | Serial bus data line (asynchronous) |
| wd_sel | input | 2 | Watchdog period select (see R5) |
| supply_ok | input | 1 | Digital supply-good indication; low holds reset |
| rst_n_o | output | 1 | Active-low supervisory reset |

## Verification
The bench lets a short period expire and checks the reset edges within one tick on each side of the expected tick. A design with the wrong encoding, or one that reset too early or too late, misses that window. A fake START with SCL low is placed inside a live period; a detector that ignored SCL would push the expiry out and leave the reset high when it should be low. A real START placed inside the reset pulse catches a design that cancels or re-times the reset. A period change in flight, and a long stretch with the watchdog off, expose a design that keeps the stale count or that keeps counting while off.

// File: rtl/wdsup_pkg.sv
// Shared types for the bus-start watchdog supervisor.
// Assumes: the period select keeps its bit encoding because the timer
// decodes it directly.
package wdsup_pkg;

    // Watchdog period select encoding.
    typedef enum logic [1:0] {
        SEL_LONG  = 2'b00,
        SEL_MID   = 2'b01,
        SEL_SHORT = 2'b10,
        SEL_OFF   = 2'b11
    } wd_sel_e;

    // Supervisor state: holding reset, or watching the bus.
    typedef enum logic {
        ST_HOLD  = 1'b0,
        ST_WATCH = 1'b1
    } sup_state_e;

endpackage

// File: rtl/wdsup_sync.sv
// Multi-bit synchronizer: each bit gets its own chain of STAGES flops.
// Assumes: the bits are independent levels, not a coherent bus value.
// No reset, so it can also carry the supply-good level that forms the reset.
module wdsup_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] stg;

        // Shift the asynchronous level through the flop chain.
        always_ff @(posedge clk) begin
            stg <= {stg[STAGES-2:0], d[b]};
        end

        assign q[b] = stg[STAGES-1];
    end

endmodule

// File: rtl/wdsup_start_det.sv
// Detects a bus START: synchronized SDA goes from high to low while
// synchronized SCL has been high for the current and previous cycles.
// Assumes: its inputs are already synchronized to clk. Reset is synchronous
// and active low.
module wdsup_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start
);

    logic scl_d;
    logic sda_d;

    // Keep the previous sample of both lines (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // A START needs SCL high across the SDA falling edge.
    assign start = scl_s & scl_d & sda_d & ~sda_s;

    // R3: a falling edge lasts one cycle, so a START pulse never repeats back to back.
    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

endmodule

// File: rtl/wdsup_timer.sv
// Supervisor timer: holds reset for RST_TICKS ticks, then watches for
// START pulses, and drops back into the hold when the selected period
// runs out. All counting advances on tick only.
// Assumes: start and sel are synchronous to clk. Reset is synchronous and
// active low.
module wdsup_timer
    import wdsup_pkg::*;
#(
    parameter int SHORT_TICKS = 250,
    parameter int MID_TICKS   = 750,
    parameter int LONG_TICKS  = 1750,
    parameter int RST_TICKS   = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [1:0] sel,
    output logic       hold
);

    localparam int MAX_A = (SHORT_TICKS > MID_TICKS) ? SHORT_TICKS : MID_TICKS;
    localparam int MAX_P = (MAX_A > LONG_TICKS) ? MAX_A : LONG_TICKS;
    localparam int CNT_W = $clog2(MAX_P + 1);
    localparam int RST_W = $clog2(RST_TICKS + 1);

    sup_state_e       state;
    logic [CNT_W-1:0] wd_cnt;
    logic [RST_W-1:0] rst_cnt;
    logic [1:0]       sel_q;

    // Map a select code to its period in ticks; off maps to zero.
    function automatic logic [CNT_W-1:0] period_of(input logic [1:0] s);
        case (s)
            SEL_SHORT: period_of = CNT_W'(SHORT_TICKS);
            SEL_MID:   period_of = CNT_W'(MID_TICKS);
            SEL_LONG:  period_of = CNT_W'(LONG_TICKS);
            default:   period_of = '0;
        endcase
    endfunction

    // Hold/watch sequencing with its reset and watchdog counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HOLD;
            rst_cnt <= RST_W'(RST_TICKS);
            wd_cnt  <= '0;
            sel_q   <= SEL_OFF;
        end else begin
            case (state)
                ST_HOLD: begin
                    if (tick) begin
                        if (rst_cnt <= RST_W'(1)) begin
                            state  <= ST_WATCH;
                            wd_cnt <= period_of(sel);
                            sel_q  <= sel;
                        end else begin
                            rst_cnt <= rst_cnt - RST_W'(1);
                        end
                    end
                end
                default: begin
                    if (start) begin
                        wd_cnt <= period_of(sel);
                        sel_q  <= sel;
                    end else if (tick) begin
                        if (sel != sel_q) begin
                            wd_cnt <= period_of(sel);
                            sel_q  <= sel;
                        end else if (sel_q == SEL_OFF) begin
                            wd_cnt <= wd_cnt;
                        end else if (wd_cnt <= CNT_W'(1)) begin
                            state   <= ST_HOLD;
                            rst_cnt <= RST_W'(RST_TICKS);
                        end else begin
                            wd_cnt <= wd_cnt - CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign hold = (state == ST_HOLD);

    // R7: a START during the hold changes neither the hold nor its count.
    assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && start && !tick) |=> (state == ST_HOLD && $stable(rst_cnt)));

    // R4, R6: the last tick of a live period enters a full-length hold.
    assert_expire_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH && tick && !start && sel == sel_q && sel_q != SEL_OFF
         && wd_cnt == CNT_W'(1)) |=> (state == ST_HOLD && rst_cnt == RST_W'(RST_TICKS)));

    // R8: leaving the hold always starts with the full period of the latched select.
    assert_release_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_WATCH) |-> (wd_cnt == period_of(sel_q)));

    // R10: a settled off selection never leads into a hold.
    assert_off_no_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH && sel == SEL_OFF && sel_q == SEL_OFF) |=> (state == ST_WATCH));

    // R3: the watchdog count never exceeds the longest period.
    assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH) |-> (wd_cnt <= CNT_W'(MAX_P)));

endmodule

// File: rtl/bus_wdog_supervisor.sv
// Top of the bus-start watchdog supervisor. It synchronizes the bus lines
// and supply-good, detects START conditions and runs the hold/watch timer.
// Assumes: supply-good low holds the synchronous internal reset, and the
// output is forced low combinationally while supply-good is low.
module bus_wdog_supervisor #(
    parameter int SHORT_TICKS = 250,
    parameter int MID_TICKS   = 750,
    parameter int LONG_TICKS  = 1750,
    parameter int RST_TICKS   = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       tick_ms,
    input  logic       scl,
    input  logic       sda,
    input  logic [1:0] wd_sel,
    input  logic       supply_ok,
    output logic       rst_n_o
);

    logic [1:0] bus_s;
    logic       pwr_s;
    logic       start;
    logic       hold;

    // Bus lines into the clock domain.
    wdsup_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_bus_sync (
        .clk (clk),
        .d   ({scl, sda}),
        .q   (bus_s)
    );

    // Supply-good into the clock domain; it serves as the internal reset.
    wdsup_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pwr_sync (
        .clk (clk),
        .d   (supply_ok),
        .q   (pwr_s)
    );

    wdsup_start_det u_start (
        .clk   (clk),
        .rst_n (pwr_s),
        .scl_s (bus_s[1]),
        .sda_s (bus_s[0]),
        .start (start)
    );

    wdsup_timer #(
        .SHORT_TICKS (SHORT_TICKS),
        .MID_TICKS   (MID_TICKS),
        .LONG_TICKS  (LONG_TICKS),
        .RST_TICKS   (RST_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (pwr_s),
        .tick  (tick_ms),
        .start (start),
        .sel   (wd_sel),
        .hold  (hold)
    );

    // Reset output: forced low by a missing supply, else follows the hold.
    assign rst_n_o = supply_ok & ~hold;

endmodule

// File: tb/tb_bus_wdog_supervisor.sv
// Scoreboard bench: the driver queues expected reset levels at tick
// numbers and a monitor compares them as the ticks go by.
module tb_bus_wdog_supervisor;

    localparam int S  = 20;
    localparam int M  = 60;
    localparam int L  = 140;
    localparam int R  = 20;
    localparam int TD = 8;

    logic       clk = 1'b0;
    logic       tick_ms = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [1:0] wd_sel = 2'b10;
    logic       supply_ok = 1'b0;
    logic       rst_n_o;

    int checks = 0;
    int errors = 0;
    int tick_num = 0;
    int div = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } exp_t;
    exp_t expq[$];

    always #5 clk = ~clk;

    bus_wdog_supervisor #(
        .SHORT_TICKS (S),
        .MID_TICKS   (M),
        .LONG_TICKS  (L),
        .RST_TICKS   (R)
    ) dut (
        .clk       (clk),
        .tick_ms   (tick_ms),
        .scl       (scl),
        .sda       (sda),
        .wd_sel    (wd_sel),
        .supply_ok (supply_ok),
        .rst_n_o   (rst_n_o)
    );

    // Tick generator: one clk-wide pulse every TD cycles, driven at negedge.
    always @(negedge clk) begin
        div     <= (div == TD - 1) ? 0 : div + 1;
        tick_ms <= (div == 0);
    end

    // Count the ticks the design has consumed.
    always @(posedge clk) begin
        if (tick_ms) tick_num <= tick_num + 1;
    end

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rst_n_o=%0b expected %0b (tick %0d)", tag, act, exp, tick_num);
        end
    endtask

    task automatic expect_rel(input int rel, input logic v, input string tag);
        exp_t e;
        e.at  = tick_num + rel;
        e.val = v;
        e.tag = tag;
        expq.push_back(e);
    endtask

    // Monitor: pop every expectation whose tick has been reached.
    always @(negedge clk) begin
        for (int i = expq.size() - 1; i >= 0; i--) begin
            if (expq[i].at <= tick_num) begin
                check(rst_n_o, expq[i].val, expq[i].tag);
                expq.delete(i);
            end
        end
    end

    task automatic wait_until(input int t);
        @(negedge clk);
        while (tick_num < t) @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        int t;
        t = tick_num + n;
        wait_until(t);
    endtask

    // Real START (SDA falls with SCL high) or a fake one (SDA falls with SCL low).
    task automatic bus_event(input bit real_start);
        if (real_start) begin
            sda = 1'b0;
            repeat (2) @(negedge clk);
            scl = 1'b0;
            repeat (2) @(negedge clk);
            sda = 1'b1;
            repeat (2) @(negedge clk);
            scl = 1'b1;
        end else begin
            scl = 1'b0;
            @(negedge clk);
            sda = 1'b0;
            repeat (2) @(negedge clk);
            sda = 1'b1;
            repeat (2) @(negedge clk);
            scl = 1'b1;
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog for a hung run.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            report();
            $finish;
        end
    end

    initial begin
        int b;
        int c;
        int d;
        int e;
        int f;
        int g;
        // R1: reset state with the supply down.
        repeat (12) @(negedge clk);
        check(rst_n_o, 1'b0, "R1 reset state");

        // R2: power-on hold.
        wait_ticks(1);
        supply_ok = 1'b1;
        expect_rel(R - 1, 1'b0, "R2 power-on hold");
        expect_rel(R + 1, 1'b1, "R2 power-on release");
        wait_ticks(R + 3);

        // R3, R4, R6, R7, R8, R11: short period with refresh, fake and ignored STARTs.
        b = tick_num;
        bus_event(1'b1);
        expect_rel(S - 1, 1'b1, "R3 refresh keeps reset high");
        expect_rel(S + 1, 1'b0, "R4 expiry asserts reset (R11 fake ignored)");
        expect_rel(S + R - 1, 1'b0, "R6 reset length (R7 start ignored)");
        expect_rel(S + R + 1, 1'b1, "R6 reset release");
        expect_rel(S + R + S - 1, 1'b1, "R8 reload after release");
        expect_rel(S + R + S + 1, 1'b0, "R8 full period after release");
        wait_until(b + 5);
        bus_event(1'b0);
        wait_until(b + S + 5);
        bus_event(1'b1);
        wait_until(b + 2 * S + 2 * R + 3);

        // R5, R9: switch to the middle period while watching.
        c = tick_num;
        wd_sel = 2'b01;
        expect_rel(S + 2, 1'b1, "R9 old period discarded");
        expect_rel(M, 1'b1, "R5 mid period not yet expired");
        expect_rel(M + 2, 1'b0, "R5 mid period expiry");
        wait_until(c + 1 + M + R + 2);

        // R5: long period, selected together with a START.
        d = tick_num;
        wd_sel = 2'b00;
        bus_event(1'b1);
        expect_rel(L - 1, 1'b1, "R5 long period not yet expired");
        expect_rel(L + 1, 1'b0, "R5 long period expiry");
        wait_until(d + L + R + 2);

        // R10: watchdog off, then back on.
        e = tick_num;
        wd_sel = 2'b11;
        expect_rel(S + 5, 1'b1, "R10 off: no reset");
        expect_rel(M + 5, 1'b1, "R10 off: no reset");
        expect_rel(L + R + 20, 1'b1, "R10 off: no reset");
        wait_until(e + L + R + 21);
        f = tick_num;
        wd_sel = 2'b10;
        expect_rel(S, 1'b1, "R10 re-enabled period not yet expired");
        expect_rel(S + 2, 1'b0, "R10 re-enabled period expiry");
        wait_until(f + 1 + S + R + 2);

        // R1, R2: supply drop while watching, then power-on again.
        supply_ok = 1'b0;
        #1;
        check(rst_n_o, 1'b0, "R1 async assert on supply loss");
        repeat (3) @(negedge clk);
        supply_ok = 1'b1;
        g = tick_num;
        expect_rel(R - 1, 1'b0, "R2 second power-on hold");
        expect_rel(R + 1, 1'b1, "R2 second power-on release");
        wait_until(g + R + 3);

        wait_ticks(2);
        if (expq.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d pending, expected 0", expq.size());
        end
        done = 1'b1;
        report();
        $finish;
    end

endmodule